// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block sits beside the on-time generator of a synchronous buck control core and decides when the converter runs in a light-load pulse-skipping mode. Once per switching cycle the core presents a cycle strobe. With it comes a flag that tells whether the inductor-current zero-crossing comparator tripped during the cycle that just ended. A two-bit mode request picks between shutdown, forced continuous conduction and pulse skipping allowed.

When skipping is allowed and the current has reached zero on a long enough unbroken run of cycles, the block enters skip mode. In skip mode it stretches the on-time count sent to the high-side one-shot by half. It also asks the low-side driver to release at the zero crossing. The first cycle that ends without a crossing drops the mode at once. In shutdown the block tells the driver stage to float both outputs. Every mode change is taken only at a cycle strobe.

Top module: `skip_mode_ctrl`

## Requirements
- R1: With pulse skipping allowed, `skip_active` rises at the clock edge that samples the eighth consecutive strobe carrying `zc_seen`=1, and not before.
- R2: A strobe with `zc_seen`=0 clears `skip_active` at that same edge, with no extra delay.
- R3: The run count saturates. Further crossing strobes keep the mode active. After any exit, a full new run of eight crossing strobes is needed to re-enter.
- R4: `ton_cnt` equals `ton_base` while inactive. While active it equals `ton_base + floor(ton_base/2)`, carried in one extra bit so it never wraps.
- R5: `ls_release_zc` is high exactly when `skip_active` is high.
- R6: Mode encoding of `mode_req`: 2'b00 off, 2'b01 forced continuous, 2'b10 skip allowed, 2'b11 forced continuous. In forced continuous the mode is never entered, and the run count is cleared at every strobe.
- R7: A strobe with mode off sets `drv_hiz`, clears `skip_active` and clears the run count. A later strobe in another mode clears `drv_hiz`.
- R8: `mode_req` and `zc_seen` are sampled only on strobe cycles. Between strobes, `skip_active`, `drv_hiz` and `ls_release_zc` hold their values.
- R9: After reset, `drv_hiz`=1, `skip_active`=0, and `ton_cnt` equals `ton_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe marking the end of a switching cycle |
| zc_seen | input | 1 | Inductor current crossed zero during the ending cycle |
| mode_req | input | 2 | Requested mode: 00 off, 01/11 forced continuous, 10 skip allowed |
| ton_base | input | TON_W | Base on-time count from the on-time generator |
| skip_active | output | 1 | Pulse-skip mode active |
| ton_cnt | output | TON_W+1 | On-time count for the high-side one-shot |
| ls_release_zc | output | 1 | Release the low-side switch at the zero crossing |
| drv_hiz | output | 1 | Float both gate driver outputs (controller disabled) |

## Verification
Mode, run-count and shutdown results are registered at the edge that samples a strobe. The on-time count is combinational from `ton_base` and the current mode state. The bench drives every input half a period before an edge, raising the strobe for exactly one edge. It then compares all four outputs at the following falling edge against a model stepped once per strobe. Between strobes the bench changes `mode_req` and `zc_seen` freely and checks after each idle edge that none of the mode outputs moved.

// File: rtl/skip_mode_pkg.sv
package skip_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_CCM  = 2'b01,
    MODE_SKIP = 2'b10,
    MODE_CCM2 = 2'b11
  } skip_mode_e;

  function automatic logic req_is_skip(input logic [1:0] req);
    return req == MODE_SKIP;
  endfunction

  function automatic logic req_is_off(input logic [1:0] req);
    return req == MODE_OFF;
  endfunction

endpackage

// File: rtl/zc_run_counter.sv
module zc_run_counter #(
  parameter int RUN_LEN = 8,
  parameter int CW      = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          advance,
  output logic [CW-1:0] run_cnt,
  output logic          run_full
);

  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = stb;

  always_comb begin
    cnt_d = cnt_q;
    if (!advance)          cnt_d = '0;
    else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_cnt  = cnt_q;
  assign run_full = (cnt_q == FULL);

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R3

  AST_RUN_FULL_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_full) |-> $past(cnt_q) == FULL - 1'b1); // R1

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb && !advance |=> cnt_q == '0); // R6

endmodule

// File: rtl/ton_stretch.sv
module ton_stretch #(
  parameter int TON_W = 10
) (
  input  logic [TON_W-1:0] base,
  input  logic             stretch,
  output logic [TON_W:0]   ton
);

  logic [TON_W:0] half_ext, base_ext;

  assign base_ext = {1'b0, base};
  assign half_ext = {2'b00, base[TON_W-1:1]};

  always_comb begin
    if (stretch) ton = base_ext + half_ext;
    else         ton = base_ext;
  end

  always_comb begin
    if (stretch) AST_STRETCH_NOT_SHORTER: assert (ton >= base_ext); // R4
  end

endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl
  import skip_mode_pkg::*;
#(
  parameter int TON_W   = 10,
  parameter int RUN_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic             zc_seen,
  input  logic [1:0]       mode_req,
  input  logic [TON_W-1:0] ton_base,
  output logic             skip_active,
  output logic [TON_W:0]   ton_cnt,
  output logic             ls_release_zc,
  output logic             drv_hiz
);

  localparam int CW = $clog2(RUN_LEN + 1);

  skip_mode_e     mode_q, mode_d;
  logic           mode_en;
  logic           advance;
  logic [CW-1:0]  run_cnt;
  logic           run_full;

  assign mode_en = cyc_stb;
  assign mode_d  = skip_mode_e'(mode_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_en) mode_q <= mode_d;
  end

  assign advance = req_is_skip(mode_req) && zc_seen;

  zc_run_counter #(.RUN_LEN(RUN_LEN), .CW(CW)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cyc_stb),
    .advance  (advance),
    .run_cnt  (run_cnt),
    .run_full (run_full)
  );

  ton_stretch #(.TON_W(TON_W)) u_ton (
    .base    (ton_base),
    .stretch (run_full),
    .ton     (ton_cnt)
  );

  assign skip_active   = run_full;
  assign ls_release_zc = run_full;
  assign drv_hiz       = (mode_q == MODE_OFF);

  AST_EXIT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb && !zc_seen |=> !skip_active); // R2

  AST_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb && req_is_off(mode_req) |=> drv_hiz && !skip_active); // R7

  AST_CCM_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb && !req_is_skip(mode_req) |=> !skip_active); // R6

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> $stable(skip_active) && $stable(drv_hiz)); // R8

  AST_RELEASE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ls_release_zc == skip_active); // R5

  AST_ACTIVE_ONLY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    skip_active |-> mode_q == MODE_SKIP); // R1

endmodule

// File: tb/tb_skip_mode_ctrl.sv
`timescale 1ns/1ps
module tb_skip_mode_ctrl;

  localparam int TW = 10;

  logic          clk, rst_n, cyc_stb, zc_seen;
  logic [1:0]    mode_req;
  logic [TW-1:0] ton_base;
  logic          skip_active, ls_release_zc, drv_hiz;
  logic [TW:0]   ton_cnt;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  int  m_cnt;
  bit  m_act;
  logic [1:0] m_mode;

  skip_mode_ctrl #(.TON_W(TW), .RUN_LEN(8)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .zc_seen(zc_seen),
    .mode_req(mode_req), .ton_base(ton_base), .skip_active(skip_active),
    .ton_cnt(ton_cnt), .ls_release_zc(ls_release_zc), .drv_hiz(drv_hiz)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [TW:0] exp_ton(input logic [TW-1:0] b, input bit act);
    int v;
    v = act ? (int'(b) + int'(b) / 2) : int'(b);
    return v[TW:0];
  endfunction

  function automatic bit exp_hiz(input logic [1:0] m);
    return m == 2'b00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R1/R2 skip_active"}, skip_active, m_act);
    chk({tag, " R5 ls_release_zc"}, ls_release_zc, m_act);
    chk({tag, " R4 ton_cnt"}, ton_cnt, exp_ton(ton_base, m_act));
    chk({tag, " R7 drv_hiz"}, drv_hiz, exp_hiz(m_mode));
  endtask

  task automatic strobe(input bit zc, input logic [1:0] m, input logic [TW-1:0] b);
    @(negedge clk);
    cyc_stb = 1; zc_seen = zc; mode_req = m; ton_base = b;
    @(posedge clk);
    if (m == 2'b10 && zc) m_cnt = (m_cnt < 8) ? m_cnt + 1 : 8;
    else m_cnt = 0;
    m_act = (m_cnt == 8);
    m_mode = m;
    @(negedge clk);
    cyc_stb = 0;
    check_all("strobe");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      zc_seen = 1'($urandom);
      mode_req = 2'($urandom);
      @(posedge clk);
      @(negedge clk);
      // R8: nothing moves without a strobe
      chk("idle R8 skip_active", skip_active, m_act);
      chk("idle R8 drv_hiz", drv_hiz, exp_hiz(m_mode));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cyc_stb = 0; zc_seen = 0; mode_req = 2'b10; ton_base = 10'd101;
    m_cnt = 0; m_act = 0; m_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("reset R9");
    rst_n = 1;
    @(negedge clk);
    check_all("post-reset R9");

    // R1: seven crossings do not enter, the eighth does
    for (int i = 0; i < 7; i++) strobe(1, 2'b10, 10'd7);
    chk("R1 not after seven", skip_active, 0);
    strobe(1, 2'b10, 10'd7);
    chk("R1 enter on eighth", skip_active, 1);
    chk("R4 stretched 7->10", ton_cnt, 10);
    // R3: saturation keeps the mode
    for (int i = 0; i < 12; i++) strobe(1, 2'b10, 10'd1023);
    chk("R3 stays active", skip_active, 1);
    chk("R4 no wrap 1023->1534", ton_cnt, 1534);
    idle(3);
    // R2: one miss exits at once
    strobe(0, 2'b10, 10'd1023);
    chk("R2 exit", skip_active, 0);
    chk("R4 unstretched", ton_cnt, 1023);
    // R3: re-entry needs a full run
    for (int i = 0; i < 7; i++) strobe(1, 2'b10, 10'd20);
    chk("R3 re-entry not early", skip_active, 0);
    strobe(1, 2'b10, 10'd20);
    chk("R3 re-entry on eighth", skip_active, 1);
    // R6: forced continuous drops out and never enters
    strobe(1, 2'b01, 10'd20);
    chk("R6 ccm drops", skip_active, 0);
    for (int i = 0; i < 10; i++) strobe(1, 2'b11, 10'd20);
    chk("R6 ccm2 never enters", skip_active, 0);
    // R7: off clears run count and floats drivers
    for (int i = 0; i < 5; i++) strobe(1, 2'b10, 10'd3);
    strobe(1, 2'b00, 10'd3);
    chk("R7 hiz on off", drv_hiz, 1);
    for (int i = 0; i < 7; i++) strobe(1, 2'b10, 10'd3);
    chk("R7 run cleared by off", skip_active, 0);
    chk("R7 hiz released", drv_hiz, 0);
    // R8: mode request ignored between strobes
    idle(6);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      int r;
      r = $urandom_range(0, 99);
      m = (r < 75) ? 2'b10 : 2'($urandom);
      strobe(($urandom_range(0, 99) < 90), m, 10'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule